// File: doc/BRIEF.md
# Process-Tagged Direct-Mapped Address Translation Buffer

This block caches virtual-to-physical page translations so that a memory access can be translated within the same cycle it is presented. A 32-bit virtual address is cut into a page number and a 12-bit page offset. The low bits of the page number pick one slot out of 512. The remaining upper bits are compared against the tag stored in that slot. Every slot also records the identifier of the process that owns it. This lets translations belonging to several processes share the buffer without a flush on every context switch.

A lookup is purely combinational. It needs three things to agree: the slot is valid, its stored process identifier equals the identifier presented with the lookup, and its tag equals the upper page-number bits. When all three hold, the physical address is the stored 18-bit physical page number followed by the unchanged offset, for a 30-bit result.

Software or a miss handler outside this block uses a fill port to load one slot after a miss. When a process terminates, a single pulse on the flush port drops every slot that process owns. Walking the page table and handling faults are left to the surrounding logic.

Top module: `tlb_dm`

## Requirements
- R1: After a synchronous active-low reset every slot is invalid, so every lookup reports a miss until a fill occurs.
- R2: After a fill of page number V for process P with physical page F, a lookup with page number V and process P reports a hit with lk_paddr[29:12] equal to F.
- R3: On a hit, lk_paddr[11:0] equals lk_vaddr[11:0] for every offset value.
- R4: A lookup whose page number matches a valid slot but whose process identifier differs from the stored one reports a miss.
- R5: A lookup that selects a valid slot (same index = page-number bits [8:0], same process) but whose tag (page-number bits [19:9]) differs reports a miss.
- R6: A fill replaces whatever the indexed slot held, so an earlier translation sharing index bits [8:0] misses afterwards.
- R7: A fill takes effect at the next rising clock edge. A lookup in the same cycle as the fill still sees the previous slot contents.
- R8: A flush pulse with process identifier P clears, at the next edge, every valid slot owned by P and leaves slots of other processes untouched.
- R9: When a fill and a flush of the fill's own process occur in the same cycle, the filled slot ends valid while the other slots of that process are cleared.
- R10: On a miss, lk_paddr is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_pid | input | 8 | Identifier of the running process |
| lk_hit | output | 1 | Translation found |
| lk_paddr | output | 30 | Physical address; zero on a miss |
| fill_en | input | 1 | Write one slot at the next edge |
| fill_vpn | input | 20 | Virtual page number being loaded |
| fill_pid | input | 8 | Owning process of the loaded slot |
| fill_ppn | input | 18 | Physical page number being loaded |
| flush_en | input | 1 | Drop all slots of flush_pid at the next edge |
| flush_pid | input | 8 | Process whose slots are dropped |

## Verification
Two pairs of functions can land in the same cycle. The first is a fill and a lookup of the same page, where the lookup must still reflect the old slot contents. The second is a fill and a flush naming the fill's own process, where the new slot must survive while a sibling slot of that process is dropped. The bench provokes both by raising the two controls between the same pair of edges. It judges the outcome at the ports: it looks up the page inside that cycle, then looks up the filled page and the sibling page after the edge.

// File: rtl/tlb_pkg.sv
// Package: default geometry of the translation buffer.
// Assumes: widths are consistent (offset + index + tag == virtual width).
package tlb_pkg;
    localparam int DEF_VA_W  = 32;
    localparam int DEF_OFF_W = 12;
    localparam int DEF_IDX_W = 9;
    localparam int DEF_PPN_W = 18;
    localparam int DEF_PID_W = 8;
endpackage

// File: rtl/tlb_vpn_split.sv
// Splits a virtual page number into slot index (low bits) and tag (high bits).
// Assumes: VPN_W > IDX_W.
module tlb_vpn_split #(
    parameter int VPN_W = 20,
    parameter int IDX_W = 9,
    localparam int TAG_W = VPN_W - IDX_W
) (
    input  logic [VPN_W-1:0] vpn,
    output logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] tag
);
    // Purpose: pure wiring of the two fields.
    always_comb begin
        idx = vpn[IDX_W-1:0];
        tag = vpn[VPN_W-1:IDX_W];
    end
endmodule

// File: rtl/tlb_slot_store.sv
// Slot storage: per-slot valid and owner in flops (flushable in parallel),
// tag and physical page in plain storage. One write port, one read port.
// Assumes: a fill to a slot outranks a same-cycle flush of that slot.
module tlb_slot_store #(
    parameter int IDX_W = 9,
    parameter int TAG_W = 11,
    parameter int PPN_W = 18,
    parameter int PID_W = 8,
    localparam int SLOTS = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PID_W-1:0] wr_pid,
    input  logic [PPN_W-1:0] wr_ppn,
    input  logic             fl_en,
    input  logic [PID_W-1:0] fl_pid,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    output logic [PID_W-1:0] rd_pid,
    output logic [PPN_W-1:0] rd_ppn
);
    logic [SLOTS-1:0] valid_q;
    logic [PID_W-1:0] pid_q [SLOTS];
    logic [TAG_W-1:0] tag_q [SLOTS];
    logic [PPN_W-1:0] ppn_q [SLOTS];

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic hit_wr;
        logic hit_fl;
        always_comb begin
            hit_wr = wr_en && (wr_idx == IDX_W'(s));
            hit_fl = fl_en && (pid_q[s] == fl_pid);
        end

        // Purpose: valid bit, fill sets (winning), flush clears, reset clears.
        always_ff @(posedge clk) begin
            if (!rst_n)      valid_q[s] <= 1'b0;
            else if (hit_wr) valid_q[s] <= 1'b1;
            else if (hit_fl) valid_q[s] <= 1'b0;
        end

        // Purpose: owning process, loaded on fill.
        always_ff @(posedge clk) begin
            if (!rst_n)      pid_q[s] <= '0;
            else if (hit_wr) pid_q[s] <= wr_pid;
        end
    end

    // Purpose: tag and physical page payload, written on fill.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            ppn_q[wr_idx] <= wr_ppn;
        end
    end

    // Purpose: asynchronous read of the indexed slot.
    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_pid   = pid_q[rd_idx];
        rd_tag   = tag_q[rd_idx];
        rd_ppn   = ppn_q[rd_idx];
    end
endmodule

// File: rtl/tlb_hit_logic.sv
// Compares a read slot against the lookup and forms the physical address.
// Assumes: the physical address is zero whenever there is no hit.
module tlb_hit_logic #(
    parameter int TAG_W = 11,
    parameter int PPN_W = 18,
    parameter int PID_W = 8,
    parameter int OFF_W = 12,
    localparam int PA_W = PPN_W + OFF_W
) (
    input  logic             slot_valid,
    input  logic [TAG_W-1:0] slot_tag,
    input  logic [PID_W-1:0] slot_pid,
    input  logic [PPN_W-1:0] slot_ppn,
    input  logic [TAG_W-1:0] req_tag,
    input  logic [PID_W-1:0] req_pid,
    input  logic [OFF_W-1:0] req_off,
    output logic             hit,
    output logic [PA_W-1:0]  paddr
);
    // Purpose: three-way match and address concatenation.
    always_comb begin
        hit   = slot_valid && (slot_pid == req_pid) && (slot_tag == req_tag);
        paddr = hit ? {slot_ppn, req_off} : '0;
    end
endmodule

// File: rtl/tlb_dm.sv
// Top: process-tagged direct-mapped translation buffer.
// Lookup is combinational; fill and flush act on the next rising edge.
// Assumes: synchronous active-low reset; caller holds fill/flush low in reset.
module tlb_dm #(
    parameter int VA_W  = tlb_pkg::DEF_VA_W,
    parameter int OFF_W = tlb_pkg::DEF_OFF_W,
    parameter int IDX_W = tlb_pkg::DEF_IDX_W,
    parameter int PPN_W = tlb_pkg::DEF_PPN_W,
    parameter int PID_W = tlb_pkg::DEF_PID_W,
    localparam int VPN_W = VA_W - OFF_W,
    localparam int TAG_W = VPN_W - IDX_W,
    localparam int PA_W  = PPN_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic [PID_W-1:0] lk_pid,
    output logic             lk_hit,
    output logic [PA_W-1:0]  lk_paddr,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PID_W-1:0] fill_pid,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             flush_en,
    input  logic [PID_W-1:0] flush_pid
);
    logic [IDX_W-1:0] lk_idx, wr_idx;
    logic [TAG_W-1:0] lk_tag, wr_tag;
    logic             rd_valid;
    logic [TAG_W-1:0] rd_tag;
    logic [PID_W-1:0] rd_pid;
    logic [PPN_W-1:0] rd_ppn;

    tlb_vpn_split #(.VPN_W(VPN_W), .IDX_W(IDX_W)) u_split_lk (
        .vpn(lk_vaddr[VA_W-1:OFF_W]), .idx(lk_idx), .tag(lk_tag)
    );

    tlb_vpn_split #(.VPN_W(VPN_W), .IDX_W(IDX_W)) u_split_wr (
        .vpn(fill_vpn), .idx(wr_idx), .tag(wr_tag)
    );

    tlb_slot_store #(
        .IDX_W(IDX_W), .TAG_W(TAG_W), .PPN_W(PPN_W), .PID_W(PID_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(fill_en), .wr_idx(wr_idx), .wr_tag(wr_tag),
        .wr_pid(fill_pid), .wr_ppn(fill_ppn),
        .fl_en(flush_en), .fl_pid(flush_pid),
        .rd_idx(lk_idx), .rd_valid(rd_valid), .rd_tag(rd_tag),
        .rd_pid(rd_pid), .rd_ppn(rd_ppn)
    );

    tlb_hit_logic #(
        .TAG_W(TAG_W), .PPN_W(PPN_W), .PID_W(PID_W), .OFF_W(OFF_W)
    ) u_hit (
        .slot_valid(rd_valid), .slot_tag(rd_tag), .slot_pid(rd_pid),
        .slot_ppn(rd_ppn), .req_tag(lk_tag), .req_pid(lk_pid),
        .req_off(lk_vaddr[OFF_W-1:0]), .hit(lk_hit), .paddr(lk_paddr)
    );
endmodule

// File: rtl/tlb_dm_chk.sv
// Checker: port-level properties of tlb_dm, attached by bind.
module tlb_dm_chk #(
    parameter int VA_W  = 32,
    parameter int OFF_W = 12,
    parameter int PPN_W = 18,
    parameter int PID_W = 8,
    localparam int VPN_W = VA_W - OFF_W,
    localparam int PA_W  = PPN_W + OFF_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic [VA_W-1:0]  lk_vaddr,
    input logic [PID_W-1:0] lk_pid,
    input logic             lk_hit,
    input logic [PA_W-1:0]  lk_paddr,
    input logic             fill_en,
    input logic [VPN_W-1:0] fill_vpn,
    input logic [PID_W-1:0] fill_pid,
    input logic [PPN_W-1:0] fill_ppn,
    input logic             flush_en,
    input logic [PID_W-1:0] flush_pid
);
    assert_reset_miss_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !lk_hit);

    assert_fill_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fill_en)
         && lk_vaddr[VA_W-1:OFF_W] == $past(fill_vpn) && lk_pid == $past(fill_pid))
        |-> (lk_hit && lk_paddr[PA_W-1:OFF_W] == $past(fill_ppn)));

    assert_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]);

    assert_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(flush_en) && !$past(fill_en) && lk_pid == $past(flush_pid))
        |-> !lk_hit);

    assert_miss_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> lk_paddr == '0);
endmodule

bind tlb_dm tlb_dm_chk #(
    .VA_W(VA_W), .OFF_W(OFF_W), .PPN_W(PPN_W), .PID_W(PID_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_vaddr(lk_vaddr), .lk_pid(lk_pid),
    .lk_hit(lk_hit), .lk_paddr(lk_paddr), .fill_en(fill_en),
    .fill_vpn(fill_vpn), .fill_pid(fill_pid), .fill_ppn(fill_ppn),
    .flush_en(flush_en), .flush_pid(flush_pid)
);

// File: tb/sim_tlb_dm.sv
module sim_tlb_dm;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  lk_pid = '0;
    logic        lk_hit;
    logic [29:0] lk_paddr;
    logic        fill_en = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [7:0]  fill_pid = '0;
    logic [17:0] fill_ppn = '0;
    logic        flush_en = 1'b0;
    logic [7:0]  flush_pid = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tlb_dm u0 (
        .clk(clk), .rst_n(rst_n), .lk_vaddr(lk_vaddr), .lk_pid(lk_pid),
        .lk_hit(lk_hit), .lk_paddr(lk_paddr), .fill_en(fill_en),
        .fill_vpn(fill_vpn), .fill_pid(fill_pid), .fill_ppn(fill_ppn),
        .flush_en(flush_en), .flush_pid(flush_pid)
    );

    // vector: {vaddr[32], pid[8], exp_hit[1], exp_paddr[30]}
    localparam logic [70:0] VEC [8] = '{
        {32'h12345ABC, 8'd3, 1'b1, 30'h2ABCDABC},  // R2 R3
        {32'h12345000, 8'd3, 1'b1, 30'h2ABCD000},  // R3 zero offset
        {32'h12345ABC, 8'd4, 1'b0, 30'h0},         // R4 other process
        {32'h12545ABC, 8'd3, 1'b0, 30'h0},         // R5 same index, other tag
        {32'h00001FFF, 8'd5, 1'b1, 30'h00011FFF},  // R2 R3 max offset
        {32'h00002123, 8'd3, 1'b1, 30'h3FFFF123},  // R2 max ppn
        {32'hFFFFF7FF, 8'd7, 1'b1, 30'h000007FF},  // R2 top page, ppn 0
        {32'h00002123, 8'd5, 1'b0, 30'h0}          // R4 R10
    };

    task automatic check(input string req, input logic exp_hit, input logic [29:0] exp_pa);
        checks++;
        if (lk_hit !== exp_hit || lk_paddr !== exp_pa) begin
            errors++;
            $display("FAIL %s: hit=%0b paddr=%h expected hit=%0b paddr=%h",
                     req, lk_hit, lk_paddr, exp_hit, exp_pa);
        end
    endtask

    task automatic look(input logic [31:0] va, input logic [7:0] pid,
                        input string req, input logic eh, input logic [29:0] ep);
        @(negedge clk);
        lk_vaddr = va;
        lk_pid   = pid;
        #1 check(req, eh, ep);
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [7:0] pid, input logic [17:0] ppn);
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = vpn; fill_pid = pid; fill_ppn = ppn;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 R10: empty after reset
        look(32'h12345ABC, 8'd3, "R1", 1'b0, 30'h0);
        look(32'h00000000, 8'd0, "R1 R10", 1'b0, 30'h0);

        fill(20'h12345, 8'd3, 18'h2ABCD);
        fill(20'h00001, 8'd5, 18'h00011);
        fill(20'h00002, 8'd3, 18'h3FFFF);
        fill(20'hFFFFF, 8'd7, 18'h00000);

        for (int i = 0; i < 8; i++) begin
            look(VEC[i][70:39], VEC[i][38:31], "R2-table", VEC[i][30], VEC[i][29:0]);
        end

        // R7: lookup in the fill cycle still sees the old entry
        @(negedge clk);
        lk_vaddr = 32'h00201456; lk_pid = 8'd5;
        fill_en = 1'b1; fill_vpn = 20'h00201; fill_pid = 8'd5; fill_ppn = 18'h00022;
        #1 check("R7 before edge", 1'b0, 30'h0);
        @(negedge clk);
        fill_en = 1'b0;
        #1 check("R7 after edge", 1'b1, 30'h00022456);
        // R6: same index 1, old translation displaced
        look(32'h00001FFF, 8'd5, "R6", 1'b0, 30'h0);

        // R8: flush process 3
        @(negedge clk);
        flush_en = 1'b1; flush_pid = 8'd3;
        @(negedge clk);
        flush_en = 1'b0;
        look(32'h12345ABC, 8'd3, "R8 pid3 gone", 1'b0, 30'h0);
        look(32'h00002123, 8'd3, "R8 pid3 gone", 1'b0, 30'h0);
        look(32'h00201456, 8'd5, "R8 pid5 kept", 1'b1, 30'h00022456);
        look(32'hFFFFF7FF, 8'd7, "R8 pid7 kept", 1'b1, 30'h000007FF);

        // R9: fill and flush of the same process together
        fill(20'h00004, 8'd9, 18'h00044);
        look(32'h00004010, 8'd9, "R9 setup", 1'b1, 30'h00044010);
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = 20'h00003; fill_pid = 8'd9; fill_ppn = 18'h00033;
        flush_en = 1'b1; flush_pid = 8'd9;
        @(negedge clk);
        fill_en = 1'b0; flush_en = 1'b0;
        look(32'h00003020, 8'd9, "R9 fill wins", 1'b1, 30'h00033020);
        look(32'h00004010, 8'd9, "R9 sibling cleared", 1'b0, 30'h0);

        // R1: reset again empties everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        look(32'h00201456, 8'd5, "R1 re-reset", 1'b0, 30'h0);
        look(32'h00003020, 8'd9, "R1 re-reset", 1'b0, 30'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule